// File: doc/BRIEF.md
# Orthogonal Variable Spreading Factor Code Generator

This block produces the real-valued channelisation chip sequence of an orthogonal variable-spreading-factor code tree for a spreading factor SF = 2^n (n from 0 to 9, so SF up to 512) and a code number k. A symbol starts on a one-cycle strobe, which captures n and k. The block then emits SF chips, leftmost chip of the code word first, as a valid/ready stream. Each chip is the parity of the chip index ANDed with the n-bit bit-reversal of k. This is the same sequence the recursive tree defines: doubling the length with a code of even number 2k repeats the parent, and with odd number 2k+1 appends the parent negated.

Each chip appears as a bit and in signed plus/minus-one form, together with a flag on the final chip of the symbol. When word mode is requested at symbol start and SF is 32, the whole symbol is delivered in a single 32-bit beat instead. Bit i of that word is chip i, so each row of the generating matrix is simply the index i.

Back-pressure rules: a chip or word is presented while its valid is high and is held unchanged until `out_rdy` is sampled high on a clock edge. Only then does the next chip appear. A symbol-start strobe has priority over everything and restarts the sequence at any time.

Top module: `ovsf_code_gen`

## Requirements
- R1: After reset `chip_vld`, `word_vld` and `chip_last` are 0.
- R2: A cycle with `sym_start` high captures `sf_log2`, `code_num` and `word_mode`. In the next cycle either `chip_vld` (serial) or `word_vld` (word) is high, and the serial stream presents chip index 0.
- R3: Serial chip index i (binary 0 = +1, binary 1 = −1) is `chip_bit` = parity over j<n of i[j] AND k[n−1−j]. Code-number bits at positions n and above are ignored.
- R4: `chip_pm` is 2-bit two's complement: 2'b01 (+1) for `chip_bit`=0 and 2'b11 (−1) for `chip_bit`=1. Code 0 yields all +1.
- R5: While `chip_vld` is high and `out_rdy` is low (no start), `chip_bit`, `chip_pm`, `chip_last` and the chip index hold. The index advances by one per accepted chip.
- R6: `chip_last` is high exactly while index SF−1 is presented. After that chip is accepted, `chip_vld` falls.
- R7: Changes of `sf_log2`, `code_num` or `word_mode` between starts do not affect the symbol in progress.
- R8: A `sym_start` during a symbol abandons it and begins the new symbol at index 0 with the new settings, even when a chip is accepted in the same cycle.
- R9: An `sf_log2` value above 9 is treated as 9 (SF = 512).
- R10: With `word_mode`=1 and `sf_log2`=5 at start, `word_vld` rises next cycle and `chip_vld` stays 0. `code_word` bit i equals serial chip i. The word holds until accepted, then `word_vld` falls.
- R11: `word_mode`=1 with any `sf_log2` other than 5 is ignored and the symbol is sent serially.
- R12: With `sf_log2`=0 the symbol is one chip of value +1 with `chip_last` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sf_log2 | input | 4 | log2 of spreading factor, captured at start |
| code_num | input | 9 | Code number k, captured at start |
| word_mode | input | 1 | Request single-beat 32-chip word, captured at start |
| sym_start | input | 1 | Symbol boundary strobe |
| out_rdy | input | 1 | Consumer accepts current chip or word |
| chip_vld | output | 1 | Serial chip valid |
| chip_bit | output | 1 | Chip as binary (0 = +1, 1 = −1) |
| chip_pm | output | 2 | Chip as signed ±1 |
| chip_last | output | 1 | Final chip of the symbol |
| word_vld | output | 1 | Parallel word valid |
| code_word | output | 32 | All 32 chips, bit i = chip i |

## Verification
Every result is due exactly one clock edge after its cause. The first chip or the word appears one edge after the start strobe, and each following chip appears one edge after an edge where `out_rdy` was high. The bench drives inputs and samples outputs on the falling edge, so each check reads the state left by the rising edge just before. Stalls are checked by holding `out_rdy` low for one edge and comparing against the same expected chip. The expected chips come from the recursive tree walked top-down, not from the parity formula.

// File: rtl/ovsf_pkg.sv
package ovsf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SER  = 2'd1,
    ST_WRD  = 2'd2
  } seq_state_t;

  localparam logic [1:0] PM_PLUS  = 2'b01;
  localparam logic [1:0] PM_MINUS = 2'b11;
endpackage

// File: rtl/ovsf_cfg_latch.sv
module ovsf_cfg_latch #(
  parameter int MAX_LOG2 = 9,
  parameter int LOG2_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [LOG2_W-1:0]   n_in,
  input  logic [MAX_LOG2-1:0] code_in,
  output logic [MAX_LOG2-1:0] rev_q,
  output logic [MAX_LOG2-1:0] last_q
);
  logic [MAX_LOG2-1:0] rev_d;
  logic [MAX_LOG2-1:0] last_d;

  // Bit-reverse the low n bits of the code; higher code bits drop out.
  always_comb begin
    rev_d = '0;
    for (int j = 0; j < MAX_LOG2; j++) begin
      for (int b = 0; b < MAX_LOG2; b++) begin
        if (b + j + 1 == int'(n_in)) rev_d[j] = code_in[b];
      end
    end
  end

  // Final chip index SF-1: n low ones.
  always_comb begin
    for (int j = 0; j < MAX_LOG2; j++) last_d[j] = (j < int'(n_in));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q  <= '0;
      last_q <= '0;
    end else if (load) begin
      rev_q  <= rev_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/ovsf_chip_seq.sv
module ovsf_chip_seq
  import ovsf_pkg::*;
#(
  parameter int MAX_LOG2 = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                word_sel,
  input  logic                rdy,
  input  logic [MAX_LOG2-1:0] last_idx,
  output seq_state_t          state,
  output logic [MAX_LOG2-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (start) begin
      state <= word_sel ? ST_WRD : ST_SER;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_SER: if (rdy) begin
          if (idx == last_idx) state <= ST_IDLE;
          else                 idx   <= idx + 1'b1;
        end
        ST_WRD: if (rdy) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ovsf_chip_logic.sv
module ovsf_chip_logic #(
  parameter int MAX_LOG2 = 9
) (
  input  logic [MAX_LOG2-1:0] idx,
  input  logic [MAX_LOG2-1:0] rev,
  output logic                chip
);
  assign chip = ^(idx & rev);
endmodule

// File: rtl/ovsf_word_logic.sv
module ovsf_word_logic #(
  parameter int WORD_LOG2 = 5,
  localparam int WORD_W = 1 << WORD_LOG2
) (
  input  logic [WORD_LOG2-1:0] rev,
  output logic [WORD_W-1:0]    word
);
  // Row i of the generating matrix is the index i itself.
  for (genvar i = 0; i < WORD_W; i++) begin : g_row
    localparam logic [WORD_LOG2-1:0] ROW = WORD_LOG2'(i);
    assign word[i] = ^(ROW & rev);
  end
endmodule

// File: rtl/ovsf_code_gen.sv
module ovsf_code_gen
  import ovsf_pkg::*;
#(
  parameter int MAX_LOG2  = 9,
  parameter int WORD_LOG2 = 5,
  localparam int LOG2_W   = $clog2(MAX_LOG2 + 1),
  localparam int WORD_W   = 1 << WORD_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LOG2_W-1:0]   sf_log2,
  input  logic [MAX_LOG2-1:0] code_num,
  input  logic                word_mode,
  input  logic                sym_start,
  input  logic                out_rdy,
  output logic                chip_vld,
  output logic                chip_bit,
  output logic [1:0]          chip_pm,
  output logic                chip_last,
  output logic                word_vld,
  output logic [WORD_W-1:0]   code_word
);
  logic [LOG2_W-1:0]   n_eff;
  logic                word_sel;
  logic [MAX_LOG2-1:0] rev_q;
  logic [MAX_LOG2-1:0] last_q;
  logic [MAX_LOG2-1:0] idx;
  seq_state_t          state;
  logic                chip_raw;
  logic [WORD_W-1:0]   word_raw;

  assign n_eff    = (sf_log2 > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : sf_log2;
  assign word_sel = word_mode && (n_eff == LOG2_W'(WORD_LOG2));

  ovsf_cfg_latch #(.MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(sym_start), .n_in(n_eff),
    .code_in(code_num), .rev_q(rev_q), .last_q(last_q)
  );

  ovsf_chip_seq #(.MAX_LOG2(MAX_LOG2)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(sym_start), .word_sel(word_sel),
    .rdy(out_rdy), .last_idx(last_q), .state(state), .idx(idx)
  );

  ovsf_chip_logic #(.MAX_LOG2(MAX_LOG2)) u_chip (
    .idx(idx), .rev(rev_q), .chip(chip_raw)
  );

  ovsf_word_logic #(.WORD_LOG2(WORD_LOG2)) u_word (
    .rev(rev_q[WORD_LOG2-1:0]), .word(word_raw)
  );

  assign chip_vld  = (state == ST_SER);
  assign word_vld  = (state == ST_WRD);
  assign chip_bit  = chip_vld & chip_raw;
  assign chip_pm   = chip_bit ? PM_MINUS : PM_PLUS;
  assign chip_last = chip_vld && (idx == last_q);
  assign code_word = word_vld ? word_raw : '0;
endmodule

// File: rtl/ovsf_code_gen_chk.sv
module ovsf_code_gen_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sym_start,
  input logic              out_rdy,
  input logic              chip_vld,
  input logic              chip_bit,
  input logic              chip_last,
  input logic              word_vld,
  input logic [WORD_W-1:0] code_word
);
  // R2
  start_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> (chip_vld || word_vld));

  // R10
  one_output_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_vld && word_vld));

  // R5
  stall_holds_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_vld && !out_rdy && !sym_start) |=>
      (chip_vld && $stable(chip_bit) && $stable(chip_last)));

  // R6
  last_ends_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_vld && chip_last && out_rdy && !sym_start) |=> !chip_vld);

  // R10
  stall_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !out_rdy && !sym_start) |=> (word_vld && $stable(code_word)));
endmodule

bind ovsf_code_gen ovsf_code_gen_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_start(sym_start), .out_rdy(out_rdy),
  .chip_vld(chip_vld), .chip_bit(chip_bit), .chip_last(chip_last),
  .word_vld(word_vld), .code_word(code_word)
);

// File: tb/ovsf_code_gen_test.sv
module ovsf_code_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sf_log2 = '0;
  logic [8:0]  code_num = '0;
  logic        word_mode = 1'b0;
  logic        sym_start = 1'b0;
  logic        out_rdy = 1'b0;
  logic        chip_vld, chip_bit, chip_last, word_vld;
  logic [1:0]  chip_pm;
  logic [31:0] code_word;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ovsf_code_gen uut (
    .clk(clk), .rst_n(rst_n), .sf_log2(sf_log2), .code_num(code_num),
    .word_mode(word_mode), .sym_start(sym_start), .out_rdy(out_rdy),
    .chip_vld(chip_vld), .chip_bit(chip_bit), .chip_pm(chip_pm),
    .chip_last(chip_last), .word_vld(word_vld), .code_word(code_word)
  );

  // Tree walk: the top index bit picks the half, the code LSB says negate it.
  function automatic logic ref_chip(int i, int k, int n);
    logic s = 1'b0;
    int ii = i;
    int kk = k;
    for (int lvl = n; lvl > 0; lvl--) begin
      if ((kk & 1) == 1 && ((ii >> (lvl - 1)) & 1) == 1) s = ~s;
      kk = kk >> 1;
      ii = ii & ((1 << (lvl - 1)) - 1);
    end
    return s;
  endfunction

  task automatic chk(logic ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_sym(int n, int k, logic wm);
    @(negedge clk);
    sym_start = 1'b1; sf_log2 = 4'(n); code_num = 9'(k); word_mode = wm;
    out_rdy = 1'b0;
    @(negedge clk);
    sym_start = 1'b0;
  endtask

  // Expects the stream to be at chip 0 on entry (just after a start).
  task automatic drain(int n_eff, int k, int stall_every, bit perturb, string req);
    int sf = 1 << n_eff;
    if (perturb) begin
      sf_log2 = 4'd1; code_num = ~code_num; word_mode = 1'b1;
    end
    for (int i = 0; i < sf; i++) begin
      logic e = ref_chip(i, k, n_eff);
      if (stall_every > 0 && i % stall_every == 0) begin
        out_rdy = 1'b0;
        @(negedge clk);
        // R5 held chip
        chk(chip_vld && chip_bit == e, "R5", chip_bit, e);
      end
      chk(chip_vld, req, chip_vld, 1);
      chk(chip_bit == e, req, chip_bit, e);
      chk(chip_pm == (e ? 2'b11 : 2'b01), "R4", chip_pm, e ? 3 : 1);
      chk(chip_last == (i == sf - 1), "R6", chip_last, i == sf - 1);
      out_rdy = 1'b1;
      @(negedge clk);
    end
    out_rdy = 1'b0;
    chk(!chip_vld, "R6 end", chip_vld, 0);
  endtask

  task automatic t_reset();
    chk(!chip_vld && !word_vld && !chip_last, "R1", {chip_vld, word_vld, chip_last}, 0);
  endtask

  task automatic t_sf8_all();
    for (int k = 0; k < 8; k++) begin
      start_sym(3, k, 1'b0);
      drain(3, k, 0, 1'b0, "R2 R3");
    end
  endtask

  task automatic t_zero_code();
    start_sym(6, 0, 1'b0);
    drain(6, 0, 0, 1'b0, "R4");
  endtask

  task automatic t_high_bits();
    start_sym(3, 9'h1F5, 1'b0);   // only k=5 within n=3
    drain(3, 5, 0, 1'b0, "R3 high bits");
  endtask

  task automatic t_stall_512();
    start_sym(9, 9'h0A7, 1'b0);
    drain(9, 9'h0A7, 3, 1'b0, "R5");
  endtask

  task automatic t_mid_change();
    start_sym(4, 11, 1'b0);
    drain(4, 11, 5, 1'b1, "R7");
  endtask

  task automatic t_restart();
    start_sym(3, 3, 1'b0);
    out_rdy = 1'b1;
    repeat (3) @(negedge clk);
    sym_start = 1'b1; sf_log2 = 4'd2; code_num = 9'd2;
    @(negedge clk);
    sym_start = 1'b0;
    drain(2, 2, 0, 1'b0, "R8");
  endtask

  task automatic t_clamp();
    start_sym(12, 9'h133, 1'b0);
    drain(9, 9'h133, 0, 1'b0, "R9");
  endtask

  task automatic t_word();
    logic [31:0] e;
    for (int i = 0; i < 32; i++) e[i] = ref_chip(i, 13, 5);
    start_sym(5, 13, 1'b1);
    word_mode = 1'b0;
    chk(word_vld && !chip_vld, "R10 valid", {word_vld, chip_vld}, 2);
    chk(code_word == e, "R10 word", code_word, e);
    @(negedge clk);
    chk(word_vld && code_word == e, "R10 hold", code_word, e);
    out_rdy = 1'b1;
    @(negedge clk);
    out_rdy = 1'b0;
    chk(!word_vld, "R10 accept", word_vld, 0);
  endtask

  task automatic t_word_ignored();
    start_sym(4, 6, 1'b1);
    chk(!word_vld, "R11", word_vld, 0);
    drain(4, 6, 0, 1'b0, "R11");
  endtask

  task automatic t_sf1();
    start_sym(0, 0, 1'b0);
    drain(0, 0, 0, 1'b0, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sf8_all();
    t_zero_code();
    t_high_bits();
    t_stall_512();
    t_mid_change();
    t_restart();
    t_clamp();
    t_word();
    t_word_ignored();
    t_sf1();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule